// File: doc/BRIEF.md
# Timer Compare/Capture Channel with Pin Control

This block holds the general registers of one timer channel. Each register has its own pin, and a shared 8-bit control register sets how every register behaves. Each register has a 4-bit field in that control register. The field puts its register into one of two modes:

- **Output compare.** The register is compared with an external free-running counter value. On equality the register's pin goes low, goes high, toggles, or stays where it is with its driver switched off.
- **Input capture.** The register takes a copy of the counter value when a chosen edge arrives on its pin input.

Every register has a sticky event flag. A compare match or a capture sets it, and software clears it by writing a zero to it.

Software uses a simple write port and a combinational read port, with four addresses:

| Address | Contents |
|---|---|
| 0 | Control register |
| 1 | General register A |
| 2 | General register B |
| 3 | Event flags |

The counter itself, clock prescaling and interrupt generation belong to neighbouring blocks.

Top module: `tmr_chan_io`

## Requirements
- R1: After reset the control register reads 0, the flags read 0, both pins have `pin_oe` = 0 and `pin_out` = 0, and both general registers read 16'hFFFF.
- R2: Control bits [3:0] govern register A (pin 0) and bits [7:4] govern register B (pin 1). Within a field, bit 3 = 0 selects output compare and bit 3 = 1 selects input capture.
- R3: A control write whose field has bit 3 = 0 loads that pin's `pin_out` with field bit 2 on the clock edge of the write, so the level is visible in the following cycle.
- R4: In compare mode, a clock cycle in which `cnt_val` equals the register sets `pin_out` on the next edge according to field bits [1:0]:
  - 00 holds the pin level
  - 01 drives 0
  - 10 drives 1
  - 11 inverts the level, and inverts it again on every further consecutive matching cycle

  A non-matching cycle leaves `pin_out` unchanged.
- R5: `pin_oe` of a pin is 1 exactly when its field is in compare mode and bits [1:0] are not 00.
- R6: In capture mode, `pin_in` passes through two synchronizing flops. Field bits [1:0] choose the edge: 00 is rising, 01 is falling, and 1x is both. On the third rising clock edge after the pin changes, the register loads the `cnt_val` present at that edge. Field bit 2 has no effect in this mode, and an edge that was not selected changes nothing.
- R7: A software write to a general register takes effect in compare mode and is ignored in capture mode.
- R8: A flag is set by a match or a capture and stays set until a write to address 3 has a 0 in that flag's bit (bit 0 for A, bit 1 for B). A 1 in a bit leaves that flag unchanged. If a set and a clear arrive in the same cycle, the set wins.
- R9: Reads return the control register at address 0 in bits [7:0], register A at address 1, register B at address 2, and the flags at address 3 in bits [1:0]. All other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Write address |
| cpu_wdata | input | 16 | Write data |
| cpu_raddr | input | 2 | Read address |
| cpu_rdata | output | 16 | Read data, combinational |
| cnt_val | input | 16 | Free-running counter value |
| pin_in | input | 2 | Capture inputs, bit 0 for A, bit 1 for B |
| pin_out | output | 2 | Compare output levels |
| pin_oe | output | 2 | Compare output enables |
| flag | output | 2 | Sticky event flags |

## Verification
Every compare code is run on both pins.

- **Initial level.** The bench checks the level loaded by the control write. A design that ignored bit 2 would start every pin low.
- **Match action.** Each code is checked on the first match. A design that confused the drive-low and drive-high codes would show the wrong level after that first match.
- **Back-to-back toggling.** Consecutive matching cycles must invert the pin each cycle. A design that recognised only a new equality would freeze the pin after one toggle.

Every capture code, including both settings of the don't-care bit, is driven with rising and falling pin edges.

- **Edge selection.** A design that mixed up the edge encodings would capture on a wrong edge, or fail to set the flag on the right one.
- **Synchronizer latency.** A design with too short or too long a synchronizer would latch a counter value that the bench has not yet presented, or latch none at all.
- **Ignored writes.** Software writes during capture mode must not reach the register.
- **Flag clearing.** Writing a 1 to the other flag's bit must leave that flag set.

// File: rtl/tmr_io_pkg.sv
package tmr_io_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_CLR  = 2'b01,
    ACT_SET  = 2'b10,
    ACT_TOG  = 2'b11
  } pin_act_e;

  // Pin level after a compare match, given the action code and present level.
  function automatic logic act_level(input logic [1:0] act, input logic cur);
    logic res;
    case (pin_act_e'(act))
      ACT_CLR: res = 1'b0;
      ACT_SET: res = 1'b1;
      ACT_TOG: res = ~cur;
      default: res = cur;
    endcase
    return res;
  endfunction

  // Capture edge selection: 00 rising, 01 falling, 1x either.
  function automatic logic edge_sel_hit(input logic [1:0] sel, input logic rise,
                                        input logic fall);
    logic res;
    if (sel[1])      res = rise | fall;
    else if (sel[0]) res = fall;
    else             res = rise;
    return res;
  endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic pin_rise,
  output logic pin_fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], pin_raw};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign pin_rise = lvl & ~prev_q;
  assign pin_fall = ~lvl & prev_q;

  AST_EDGE_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) pin_rise |=> !pin_rise); // R6
endmodule

// File: rtl/tmr_gr_slot.sv
module tmr_gr_slot
  import tmr_io_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_cap,
  input  logic [1:0]       act_sel,
  input  logic             ld_init,
  input  logic             init_lvl,
  input  logic             gr_wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             rise,
  input  logic             fall,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] gr_q,
  output logic             pin_q,
  output logic             pin_oe,
  output logic             flag_q
);
  logic match_evt;
  logic cap_evt;

  assign match_evt = !mode_cap && (cnt_val == gr_q);
  assign cap_evt   = mode_cap && edge_sel_hit(act_sel, rise, fall);
  assign pin_oe    = !mode_cap && (act_sel != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gr_q <= '1;
    else if (cap_evt)           gr_q <= cnt_val;
    else if (gr_wr && !mode_cap) gr_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pin_q <= 1'b0;
    else if (ld_init)   pin_q <= init_lvl;
    else if (match_evt) pin_q <= act_level(act_sel, pin_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    flag_q <= 1'b0;
    else if (match_evt || cap_evt) flag_q <= 1'b1;
    else if (flag_clr)             flag_q <= 1'b0;
  end

  AST_INIT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) ld_init |=> pin_q == $past(init_lvl)); // R3
  AST_MATCH_LOW: assert property (@(posedge clk) disable iff (!rst_n) match_evt && !ld_init && act_sel == 2'b01 |=> !pin_q); // R4
  AST_MATCH_HIGH: assert property (@(posedge clk) disable iff (!rst_n) match_evt && !ld_init && act_sel == 2'b10 |=> pin_q); // R4
  AST_MATCH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) match_evt && !ld_init && act_sel == 2'b11 |=> pin_q != $past(pin_q)); // R4
  AST_NO_MATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !match_evt && !ld_init |=> $stable(pin_q)); // R4
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) cap_evt |=> gr_q == $past(cnt_val) && flag_q); // R6
  AST_CAPTURE_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) mode_cap && gr_wr && !cap_evt |=> $stable(gr_q)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) flag_q && !flag_clr |=> flag_q); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) match_evt |=> flag_q); // R8
endmodule

// File: rtl/tmr_chan_io.sv
module tmr_chan_io
  import tmr_io_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int FIELDS   = 2,
  parameter int SYNC_STG = 2,
  localparam int CTRL_W  = 4 * FIELDS,
  localparam int ADDR_W  = $clog2(FIELDS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [CNT_W-1:0]  cpu_wdata,
  input  logic [ADDR_W-1:0] cpu_raddr,
  output logic [CNT_W-1:0]  cpu_rdata,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic [FIELDS-1:0] pin_in,
  output logic [FIELDS-1:0] pin_out,
  output logic [FIELDS-1:0] pin_oe,
  output logic [FIELDS-1:0] flag
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(FIELDS + 1);

  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic [CNT_W-1:0]  gr_val [FIELDS];

  assign ctrl_wr = cpu_we && (cpu_addr == CTRL_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= cpu_wdata[CTRL_W-1:0];
  end

  generate
    for (genvar i = 0; i < FIELDS; i++) begin : g_slot
      logic rise_w;
      logic fall_w;
      logic gr_wr_w;
      logic clr_w;
      logic ld_w;

      assign gr_wr_w = cpu_we && (cpu_addr == ADDR_W'(i + 1));
      assign clr_w   = cpu_we && (cpu_addr == FLAG_ADDR) && !cpu_wdata[i];
      assign ld_w    = ctrl_wr && !cpu_wdata[4*i+3];

      tmr_pin_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_raw  (pin_in[i]),
        .pin_rise (rise_w),
        .pin_fall (fall_w)
      );

      tmr_gr_slot #(.CNT_W(CNT_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_cap (ctrl_q[4*i+3]),
        .act_sel  (ctrl_q[4*i +: 2]),
        .ld_init  (ld_w),
        .init_lvl (cpu_wdata[4*i+2]),
        .gr_wr    (gr_wr_w),
        .wdata    (cpu_wdata),
        .cnt_val  (cnt_val),
        .rise     (rise_w),
        .fall     (fall_w),
        .flag_clr (clr_w),
        .gr_q     (gr_val[i]),
        .pin_q    (pin_out[i]),
        .pin_oe   (pin_oe[i]),
        .flag_q   (flag[i])
      );

      AST_OE_OFF_IN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) ctrl_wr && cpu_wdata[4*i+3] |=> !pin_oe[i]); // R5
    end
  endgenerate

  always_comb begin
    cpu_rdata = '0;
    if (cpu_raddr == CTRL_ADDR) begin
      cpu_rdata[CTRL_W-1:0] = ctrl_q;
    end else if (cpu_raddr == FLAG_ADDR) begin
      cpu_rdata[FIELDS-1:0] = flag;
    end else begin
      for (int k = 0; k < FIELDS; k++) begin
        if (cpu_raddr == ADDR_W'(k + 1)) cpu_rdata = gr_val[k];
      end
    end
  end

  AST_CTRL_READBACK: assert property (@(posedge clk) disable iff (!rst_n) ctrl_wr |=> ctrl_q == $past(cpu_wdata[CTRL_W-1:0])); // R9
endmodule

// File: tb/tmr_chan_io_tb.sv
module tmr_chan_io_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [1:0]  cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic [1:0]  cpu_raddr = '0;
  logic [15:0] cpu_rdata;
  logic [15:0] cnt_val = '0;
  logic [1:0]  pin_in = '0;
  logic [1:0]  pin_out;
  logic [1:0]  pin_oe;
  logic [1:0]  flag;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tmr_chan_io dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_raddr(cpu_raddr), .cpu_rdata(cpu_rdata),
    .cnt_val(cnt_val), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .flag(flag)
  );

  function automatic logic exp_level(input logic [1:0] a, input logic cur);
    if (a == 2'b01) return 1'b0;
    if (a == 2'b10) return 1'b1;
    if (a == 2'b11) return !cur;
    return cur;
  endfunction

  function automatic logic exp_hit(input logic [1:0] sel, input logic new_lvl);
    if (sel == 2'b00) return new_lvl;
    if (sel == 2'b01) return !new_lvl;
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [15:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [15:0] d);
    cpu_raddr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #4000000;
    total++; fails++;
    $display("FAIL watchdog all-R actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] val;
    logic        lvl;
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    cpu_rd(2'd0, rd); chk("R1 ctrl", rd, 16'h0000);
    cpu_rd(2'd1, rd); chk("R1 grA", rd, 16'hFFFF);
    cpu_rd(2'd2, rd); chk("R1 grB", rd, 16'hFFFF);
    cpu_rd(2'd3, rd); chk("R1 flags", rd, 16'h0000);
    chk("R1 pins", {pin_out, pin_oe}, 4'b0000);

    // R9 address map, unused bits zero
    cpu_wr(2'd0, 16'hFFA5);
    cpu_rd(2'd0, rd); chk("R9 ctrl readback", rd, 16'h00A5);
    // R2 field layout: A capture (0x8), B compare init high drive 1 (0x6)
    cpu_wr(2'd0, 16'h0068);
    chk("R2 oe", pin_oe, 2'b10);
    chk("R2 B init", pin_out[1], 1'b1);
    cpu_wr(2'd0, 16'h0000);

    // Compare codes on both slots
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        val = 16'($urandom);
        cnt_val = ~val;
        cpu_wr(2'd1, val);
        cpu_wr(2'd2, val);
        cpu_wr(2'd3, 16'h0000);
        cpu_wr(2'd0, 16'(c << (4 * s)));
        lvl = c[2];
        chk($sformatf("R3 init s%0d c%0d", s, c), pin_out[s], lvl);
        chk($sformatf("R5 oe s%0d c%0d", s, c), pin_oe[s], c[1:0] != 2'b00);
        chk($sformatf("R8 flag idle s%0d", s), flag[s], 1'b0);
        cnt_val = val;
        step(1);
        lvl = exp_level(c[1:0], lvl);
        chk($sformatf("R4 match s%0d c%0d", s, c), pin_out[s], lvl);
        chk($sformatf("R8 flag set s%0d c%0d", s, c), flag[s], 1'b1);
        if (c[1:0] == 2'b11) begin
          for (int t = 0; t < 3; t++) begin
            step(1);
            lvl = !lvl;
            chk($sformatf("R4 back-to-back toggle s%0d t%0d", s, t), pin_out[s], lvl);
          end
        end
        cnt_val = ~val;
        step(2);
        chk($sformatf("R4 no match hold s%0d c%0d", s, c), pin_out[s], lvl);
        cpu_wr(2'd3, 16'(~(1 << s)));
        chk($sformatf("R8 clear s%0d", s), flag[s], 1'b0);
        chk($sformatf("R8 write-1 keeps s%0d", s), flag[1-s], 1'b1);
      end
    end

    // Capture codes on both slots, including the don't-care bit
    for (int s = 0; s < 2; s++) begin
      for (int c = 8; c < 16; c++) begin
        logic [15:0] prev_gr;
        cpu_wr(2'd0, 16'(c << (4 * s)));
        cpu_wr(2'd3, 16'h0000);
        chk($sformatf("R5 oe capture s%0d c%0d", s, c), pin_oe[s], 1'b0);
        cpu_rd(2'(s + 1), prev_gr);
        for (int e = 0; e < 2; e++) begin
          logic hit;
          val = 16'($urandom);
          cnt_val = val;
          pin_in[s] = !pin_in[s];
          hit = exp_hit(2'(c & 3), pin_in[s]);
          step(2);
          cpu_rd(2'(s + 1), rd);
          chk($sformatf("R6 not yet s%0d c%0d e%0d", s, c, e), rd, prev_gr);
          step(2);
          cpu_rd(2'(s + 1), rd);
          if (hit) prev_gr = val;
          chk($sformatf("R6 capture s%0d c%0d e%0d", s, c, e), rd, prev_gr);
          chk($sformatf("R8 capture flag s%0d c%0d e%0d", s, c, e), flag[s], hit);
          cpu_wr(2'd3, 16'h0000);
        end
        cpu_wr(2'(s + 1), 16'($urandom));
        cpu_rd(2'(s + 1), rd);
        chk($sformatf("R7 write ignored s%0d c%0d", s, c), rd, prev_gr);
      end
    end

    // R7 compare-mode write takes effect
    cpu_wr(2'd0, 16'h0000);
    cpu_wr(2'd1, 16'h1234);
    cpu_rd(2'd1, rd); chk("R7 compare write", rd, 16'h1234);

    // R8 set wins over clear in the same cycle
    cnt_val = 16'h1234;
    cpu_wr(2'd3, 16'h0000);
    chk("R8 set beats clear", flag[0], 1'b1);
    cnt_val = 16'h0000;

    summary();
    $finish;
  end
endmodule